// File: doc/BRIEF.md
# Multi-Device Trigger Synchronizer

This block fires a trigger on the same clock cycle on several devices. All the devices run from clocks locked to one shared reference, so the skew between them stays constant. Each device receives a slow, single-cycle epoch strobe, and that strobe lands on the same clock cycle everywhere. One device is set to the leader role. It watches a raw, unsynchronized trigger and, in step with the epoch strobes, drives a shared distribution line that carries the trigger to the other devices. The others are set to the follower role and only watch that line.

The leader does not forward a trigger as soon as it sees it. It holds the trigger as pending and raises the distribution line at the next epoch strobe. The line then stays high for exactly one epoch period. Every device samples the line and fires its synchronized trigger when the next epoch strobe finds the line high. Any delay on the line that is shorter than the epoch period therefore drops out. The leader reads its own drive register instead of the external line, so it fires on the same cycle as the followers.

Top module: `trig_sync_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dist_out` and `sync_trig` are low.
- R2: In the leader role (`is_master` = 1), `raw_trig` passes through a two-stage synchronizer. Each rising edge counts as one trigger, so a level held high for many cycles gives a single distribution.
- R3: `dist_out` rises only on the clock edge at which `epoch_stb` is high and a trigger is pending. A trigger detected in the same cycle as a strobe waits for the next strobe.
- R4: Once raised, `dist_out` stays high for exactly one epoch period and falls on the edge of the next strobe.
- R5: `sync_trig` is high for one cycle. It rises on the edge after a clock edge where `epoch_stb` was high and the line value registered one cycle earlier was high. This holds in both roles.
- R6: In the leader role, the line that is evaluated is the block's own `dist_out`, and `dist_in` has no effect on `sync_trig`.
- R7: In the follower role (`is_master` = 0), `dist_out` stays low, `raw_trig` has no effect, and the evaluated line is `dist_in`.
- R8: A rising edge of `raw_trig` that is detected while a trigger is pending or `dist_out` is high is dropped and never distributed.
- R9: A leader and a follower that receives the leader's `dist_out` with a delay shorter than one epoch period fire `sync_trig` on the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock locked to the shared reference |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = leader role, 0 = follower role |
| raw_trig | input | 1 | Unsynchronized trigger input (used in the leader role) |
| epoch_stb | input | 1 | Single-cycle epoch strobe, aligned on all devices |
| dist_in | input | 1 | Distribution line as received from the backplane |
| dist_out | output | 1 | Distribution line drive (leader role only) |
| sync_trig | output | 1 | One-cycle synchronized trigger |

## Verification
Two events can fall on one clock edge: the detection of a new trigger edge and an epoch strobe. The strobe may also coincide with the end of a distribution while a new edge arrives. The bench sweeps the raw pulse across every phase of the epoch period, so the detection pulse lands on each cycle of the period, including the strobe cycle. A behavioural reference model is compared against `dist_out` and `sync_trig` on every clock. The comparison checks that a detection on the strobe cycle waits a full period and that an edge during a distribution is dropped.

// File: rtl/trig_sync_pkg.sv
package trig_sync_pkg;
  typedef enum logic {
    ROLE_FOLLOWER = 1'b0,
    ROLE_LEADER   = 1'b1
  } role_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic rise_pulse
);
  localparam int unsigned CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= raw;
  end

  genvar g;
  generate
    for (g = 1; g < CHAIN_W; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  // last synchronized stage against its one-cycle-older copy
  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/trig_dist_ctrl.sv
module trig_dist_ctrl
  import trig_sync_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  role_e role,
  input  logic  rise,
  input  logic  epoch_stb,
  output logic  dist_drv
);
  logic pending;
  logic busy;

  assign busy = pending | dist_drv;

  always_ff @(posedge clk) begin
    if (rst || role != ROLE_LEADER) begin
      pending  <= 1'b0;
      dist_drv <= 1'b0;
    end else begin
      if (epoch_stb) begin
        dist_drv <= dist_drv ? 1'b0 : pending;
      end
      if (epoch_stb && pending) begin
        pending <= 1'b0;
      end else if (rise && !busy) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_fire_gen.sv
module trig_fire_gen (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic epoch_stb,
  output logic fire
);
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      fire   <= 1'b0;
    end else begin
      line_q <= line;
      fire   <= epoch_stb & line_q;
    end
  end
endmodule

// File: rtl/trig_sync_top.sv
module trig_sync_top
  import trig_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic is_master,
  input  logic raw_trig,
  input  logic epoch_stb,
  input  logic dist_in,
  output logic dist_out,
  output logic sync_trig
);
  localparam int unsigned STAGES_USED =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  role_e role;
  logic  rise;
  logic  drv;
  logic  eval_line;

  assign role = is_master ? ROLE_LEADER : ROLE_FOLLOWER;

  trig_edge_sync #(.STAGES(STAGES_USED)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .raw        (raw_trig),
    .rise_pulse (rise)
  );

  trig_dist_ctrl u_dist (
    .clk       (clk),
    .rst       (rst),
    .role      (role),
    .rise      (rise),
    .epoch_stb (epoch_stb),
    .dist_drv  (drv)
  );

  assign eval_line = (role == ROLE_LEADER) ? drv : dist_in;

  trig_fire_gen u_fire (
    .clk       (clk),
    .rst       (rst),
    .line      (eval_line),
    .epoch_stb (epoch_stb),
    .fire      (sync_trig)
  );

  assign dist_out = drv;
endmodule

// File: rtl/trig_sync_chk.sv
module trig_sync_chk (
  input logic clk,
  input logic rst,
  input logic is_master,
  input logic epoch_stb,
  input logic dist_out,
  input logic sync_trig
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dist_out && !sync_trig));

  // R3
  a_r3_rise_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(dist_out) |-> $past(epoch_stb));

  // R4
  a_r4_fall_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(dist_out) |-> ($past(epoch_stb) || !$past(is_master)));

  // R5
  a_r5_fire_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sync_trig |-> $past(epoch_stb));

  // R7
  a_r7_follower_silent: assert property (@(posedge clk) disable iff (rst)
    !$past(is_master) |-> !dist_out);
endmodule

bind trig_sync_top trig_sync_chk u_chk (.*);

// File: tb/tb_trig_sync_top.sv
module tb_trig_sync_top;
  localparam int PER = 8;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic raw_trig = 1'b0;
  logic epoch_stb = 1'b0;
  logic dist_in = 1'b0;
  logic dist_out, sync_trig;
  logic s_dist_out, s_sync_trig;
  logic [DLY-1:0] dly = '0;

  int n_chk = 0, n_fail = 0;
  int drise = 0, fire0 = 0, fire1 = 0;
  int width = 0;
  bit prev_dout = 0;

  always #10 clk = ~clk;

  trig_sync_top dut (.clk(clk), .rst(rst), .is_master(is_master), .raw_trig(raw_trig),
    .epoch_stb(epoch_stb), .dist_in(dist_in), .dist_out(dist_out), .sync_trig(sync_trig));

  trig_sync_top dut_slv (.clk(clk), .rst(rst), .is_master(1'b0), .raw_trig(raw_trig),
    .epoch_stb(epoch_stb), .dist_in(dly[DLY-1]), .dist_out(s_dist_out), .sync_trig(s_sync_trig));

  always @(posedge clk) dly <= {dly[DLY-2:0], dist_out};

  // strobe generator
  int scnt = 0;
  always @(negedge clk) begin
    if (rst) begin scnt = 0; epoch_stb <= 1'b0; end
    else begin
      epoch_stb <= (scnt == PER - 1);
      scnt = (scnt == PER - 1) ? 0 : scnt + 1;
    end
  end

  // behavioural reference model
  bit m_pend, m_dout, m_samp0, m_samp1, m_fire0, m_fire1;
  bit rh[$];
  always @(posedge clk) begin : model
    bit det, busy, ln0, ln1, n_pend, n_dout;
    if (rst) begin
      m_pend = 0; m_dout = 0; m_samp0 = 0; m_samp1 = 0; m_fire0 = 0; m_fire1 = 0;
      rh = '{0, 0, 0};
    end else begin
      det  = rh[1] && !rh[2];
      busy = m_pend || m_dout;
      if (!is_master) begin
        n_dout = 0; n_pend = 0;
      end else begin
        n_dout = epoch_stb ? (m_dout ? 1'b0 : m_pend) : m_dout;
        n_pend = (epoch_stb && m_pend) ? 1'b0 : ((det && !busy) ? 1'b1 : m_pend);
      end
      ln0 = is_master ? m_dout : dist_in;
      ln1 = dly[DLY-1];
      m_fire0 = epoch_stb && m_samp0;
      m_fire1 = epoch_stb && m_samp1;
      m_samp0 = ln0;
      m_samp1 = ln1;
      m_dout = n_dout;
      m_pend = n_pend;
      rh.push_front(raw_trig);
      void'(rh.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk(dist_out === m_dout, "R4 dist_out vs model", dist_out, m_dout);
      chk(sync_trig === m_fire0, "R5 sync_trig vs model", sync_trig, m_fire0);
      chk(s_sync_trig === m_fire1, "R5 follower sync_trig vs model", s_sync_trig, m_fire1);
      chk(s_dist_out === 1'b0, "R7 follower dist_out", s_dist_out, 0);
      if (is_master)
        chk(sync_trig === s_sync_trig, "R9 leader/follower same cycle", s_sync_trig, sync_trig);
      if (dist_out && !prev_dout) begin
        drise++;
        chk(epoch_stb === 1'b1, "R3 rise on strobe edge", epoch_stb, 1);
        width = 0;
      end
      if (dist_out) width++;
      if (!dist_out && prev_dout && is_master)
        chk(width == PER, "R4 distribution width", width, PER);
      if (sync_trig) fire0++;
      if (s_sync_trig) fire1++;
      prev_dout = dist_out;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int len);
    raw_trig = 1'b1; wait_cyc(len); raw_trig = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    wait_cyc(4);
    chk(dist_out === 1'b0 && sync_trig === 1'b0, "R1 outputs in reset",
        {dist_out, sync_trig}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dist_out === 1'b0 && sync_trig === 1'b0, "R1 outputs after reset",
        {dist_out, sync_trig}, 0);

    // single short pulse, leader role
    wait_cyc(5); pulse(2); wait_cyc(40);
    chk(drise == 1, "R2 one distribution per pulse", drise, 1);
    chk(fire0 == 1, "R5 leader fired once", fire0, 1);
    chk(fire1 == 1, "R9 follower fired once", fire1, 1);

    // level held high
    drise = 0; pulse(60); wait_cyc(30);
    chk(drise == 1, "R2 held level gives one distribution", drise, 1);

    // second edge while busy is dropped
    drise = 0; pulse(1); wait_cyc(3); pulse(1); wait_cyc(40);
    chk(drise == 1, "R8 edge while busy dropped", drise, 1);
    pulse(1); wait_cyc(40);
    chk(drise == 2, "R8 edge after release accepted", drise, 2);

    // phase sweep: detection on every cycle of the period, strobe included
    drise = 0;
    for (int k = 0; k < PER; k++) begin
      wait_cyc(k + 1); pulse(1); wait_cyc(30);
    end
    chk(drise == PER, "R3 phase sweep distributions", drise, PER);

    // leader ignores external line
    fire0 = 0; dist_in = 1'b1; wait_cyc(5 * PER); dist_in = 1'b0;
    chk(fire0 == 0, "R6 dist_in ignored by leader", fire0, 0);

    // follower role
    is_master = 1'b0; wait_cyc(2);
    drise = 0; fire0 = 0;
    for (int k = 0; k < 4; k++) begin pulse(2); wait_cyc(7); end
    wait_cyc(20);
    chk(drise == 0, "R7 follower never drives", drise, 0);
    chk(fire0 == 0, "R7 raw_trig ignored in follower role", fire0, 0);
    dist_in = 1'b1; wait_cyc(PER); dist_in = 1'b0; wait_cyc(3 * PER);
    chk(fire0 == 1, "R5 follower fires on line window", fire0, 1);

    wait_cyc(5);
    report();
  end
endmodule